// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank-State Checker

This block watches the command pins of a four-bank SDRAM interface without driving anything back. On every clock it samples clock-enable, chip-select, the row strobe, the column strobe, write-enable, the two bank-select bits and the address. It turns that pin pattern into a command code and keeps a small state machine per bank: idle, precharging, row open, burst read or burst write. A command that the addressed bank, or the array as a whole, cannot accept in its present state raises a one-cycle violation pulse. The pulse carries a reason code.

The monitor sits beside a memory controller in simulation or on silicon. It reports the decoded command, the bank and the address of that command, the state of all four banks and any violation. Burst length and the precharge interval are parameters, so the bank timers follow the configuration of the controller under test. Gaps between commands and the data bus are not checked.

All outputs are registered. A command sampled at clock edge N appears on the outputs, with its effect on the bank states, just after edge N.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is held, and after it, every bank reads idle (state code 0), `cmd_o` reads deselect (code 0) and `viol_o` is low.
- R2: One cycle after sampling, `cmd_o` gives the decoded command. Codes: deselect 0, nop 1, burst stop 2, read 3, read+autoprecharge 4, write 5, write+autoprecharge 6, activate 7, precharge one 8, precharge all 9, refresh 10, mode set 11, malformed mode set 12. With chip-select high or clock-enable low, the code is deselect, no bank changes and no violation is raised.
- R3: Address bit 10 has three uses. On a read or write it requests auto precharge. On a precharge it selects all banks. On a mode set it must be low together with both bank bits; otherwise the code is 12 with violation reason 6.
- R4: The bank number is {BA1, BA0} (`ba_i[1:0]`). The state of bank b sits in `bank_state_o[3b+2:3b]`: idle 0, precharging 1, row open 2, reading 3, writing 4.
- R5: Activate on an idle bank opens the row (state 2). Activate on a bank in state 2, 3 or 4 is a violation with reason 3.
- R6: A read or write to an idle bank is a violation with reason 2. A read, write or activate to a precharging bank is a violation with reason 1.
- R7: A precharge of a bank in state 2, 3 or 4 holds it in state 1 for PRE_CLKS cycles, after which it goes idle. A precharge of an idle or precharging bank is legal and changes nothing, and does not restart the interval.
- R8: A read or write holds the bank in state 3 or 4 for BURST_LEN cycles. Without auto precharge the bank then returns to state 2. With auto precharge it then precharges as in R7.
- R9: A read or write to a bursting bank restarts the burst in the new direction. A legal read or write to another bank ends every other burst: those banks go to state 2, or to state 1 if their burst had auto precharge.
- R10: Burst stop is legal only while some bank is bursting, and it returns all bursting banks to state 2. Otherwise it is a violation with reason 4.
- R11: Refresh and a well-formed mode set are legal only when all banks are idle. Otherwise they are a violation with reason 5.
- R12: A violation appears as `viol_o` high for exactly the cycle after the offending command, with the reason on `viol_code_o` (0 when there is no violation). The illegal command changes no bank, and the bank timers keep running.
- R13: Precharge-all moves every bank in state 2, 3 or 4 to state 1 and is always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_i | input | 1 | Sampled clock-enable pin |
| cs_n_i | input | 1 | Sampled chip-select, active low |
| ras_n_i | input | 1 | Sampled row strobe, active low |
| cas_n_i | input | 1 | Sampled column strobe, active low |
| we_n_i | input | 1 | Sampled write-enable, active low |
| ba_i | input | 2 | Bank-select pins, bit 0 = BA0 |
| addr_i | input | ADDR_W | Address pins |
| cmd_o | output | 4 | Decoded command code |
| cmd_bank_o | output | 2 | Bank bits of the decoded command |
| cmd_addr_o | output | ADDR_W | Address of the decoded command |
| bank_state_o | output | 3*NUM_BANKS | Per-bank state, 3 bits per bank |
| viol_o | output | 1 | One-cycle violation pulse |
| viol_code_o | output | 3 | Violation reason |

## Verification
The bench builds the block with BURST_LEN = 2 and PRE_CLKS = 3, and leaves the other parameters at their defaults. These short intervals let a directed test see a burst end, an auto precharge start and the idle return, each within a few cycles of the command. The tests also issue commands inside a still-running precharge, to show that illegal commands and repeated precharges leave the timer alone. The scenarios also cover bursts in two banks that end each other, and refresh and mode set tried while a row is still open.

// File: rtl/sdram_mon_pkg.sv
// Package: shared codes for the SDRAM command monitor.
// Assumes: four-bit command code, three-bit bank state and reason codes.
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_DESL    = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_BST     = 4'd2,
        CMD_RD      = 4'd3,
        CMD_RDA     = 4'd4,
        CMD_WR      = 4'd5,
        CMD_WRA     = 4'd6,
        CMD_ACT     = 4'd7,
        CMD_PRE     = 4'd8,
        CMD_PALL    = 4'd9,
        CMD_REF     = 4'd10,
        CMD_MRS     = 4'd11,
        CMD_MRS_BAD = 4'd12
    } cmd_e;

    typedef enum logic [2:0] {
        BS_IDLE   = 3'd0,
        BS_PRECH  = 3'd1,
        BS_ACTIVE = 3'd2,
        BS_READ   = 3'd3,
        BS_WRITE  = 3'd4
    } bank_st_e;

    typedef enum logic [2:0] {
        RSN_NONE        = 3'd0,
        RSN_PRECHARGING = 3'd1,
        RSN_IDLE_BANK   = 3'd2,
        RSN_ROW_OPEN    = 3'd3,
        RSN_NO_BURST    = 3'd4,
        RSN_NOT_IDLE    = 3'd5,
        RSN_BAD_MRS     = 3'd6
    } rsn_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
// Module: sdram_cmd_decode
// Purely combinational decoding of one cycle of SDRAM command pins into a
// command code. Assumes the auto-precharge / all-bank flag is address bit 10
// and that clock-enable low means the cycle carries no command.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 2
) (
    input  logic              cke_i,
    input  logic              cs_n_i,
    input  logic              ras_n_i,
    input  logic              cas_n_i,
    input  logic              we_n_i,
    input  logic [BA_W-1:0]   ba_i,
    input  logic [ADDR_W-1:0] addr_i,
    output cmd_e              cmd_o,
    output logic              ap_o
);
    localparam int AP_BIT = 10;

    assign ap_o = addr_i[AP_BIT];

    // Map the strobe pattern, qualified by bit 10, onto a command code.
    always_comb begin
        cmd_o = CMD_DESL;
        if (cke_i && !cs_n_i) begin
            case ({ras_n_i, cas_n_i, we_n_i})
                3'b111:  cmd_o = CMD_NOP;
                3'b110:  cmd_o = CMD_BST;
                3'b101:  cmd_o = ap_o ? CMD_RDA : CMD_RD;
                3'b100:  cmd_o = ap_o ? CMD_WRA : CMD_WR;
                3'b011:  cmd_o = CMD_ACT;
                3'b010:  cmd_o = ap_o ? CMD_PALL : CMD_PRE;
                3'b001:  cmd_o = CMD_REF;
                default: cmd_o = ((ba_i == '0) && !ap_o) ? CMD_MRS : CMD_MRS_BAD;
            endcase
        end
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
// Module: sdram_bank_tracker
// State of one SDRAM bank plus its burst / precharge timer. It reports why a
// command aimed at this bank would be illegal, and it updates only when the
// top level says the current command is legal (go_i). Assumes sel_i marks
// the bank addressed by the command and ap_i is its auto-precharge flag.
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int PRE_CLKS  = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     cmd_i,
    input  logic     sel_i,
    input  logic     ap_i,
    input  logic     go_i,
    output bank_st_e state_o,
    output rsn_e     rsn_o
);
    localparam int MAX_CNT = (BURST_LEN > PRE_CLKS) ? BURST_LEN : PRE_CLKS;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_CLKS - 1);

    bank_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ap_q, ap_d;
    logic             is_col, is_rd, row_open, bursting;

    assign is_col   = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA) ||
                      (cmd_i == CMD_WR) || (cmd_i == CMD_WRA);
    assign is_rd    = (cmd_i == CMD_RD) || (cmd_i == CMD_RDA);
    assign bursting = (state_q == BS_READ) || (state_q == BS_WRITE);
    assign row_open = bursting || (state_q == BS_ACTIVE);
    assign state_o  = state_q;

    // Judge a bank-targeted command against this bank's state.
    always_comb begin
        rsn_o = RSN_NONE;
        if (is_col) begin
            if (state_q == BS_PRECH)     rsn_o = RSN_PRECHARGING;
            else if (state_q == BS_IDLE) rsn_o = RSN_IDLE_BANK;
        end else if (cmd_i == CMD_ACT) begin
            if (state_q == BS_PRECH) rsn_o = RSN_PRECHARGING;
            else if (row_open)       rsn_o = RSN_ROW_OPEN;
        end
    end

    // Timer tick first, then a legal command overrides it.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ap_d    = ap_q;
        case (state_q)
            BS_PRECH: begin
                if (cnt_q == '0) state_d = BS_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            BS_READ, BS_WRITE: begin
                if (cnt_q == '0) begin
                    if (ap_q) begin
                        state_d = BS_PRECH;
                        cnt_d   = PRE_LAST;
                    end else begin
                        state_d = BS_ACTIVE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: ;
        endcase
        if (go_i) begin
            if (sel_i && (cmd_i == CMD_ACT)) begin
                state_d = BS_ACTIVE;
            end else if (sel_i && is_col) begin
                state_d = is_rd ? BS_READ : BS_WRITE;
                cnt_d   = BURST_LAST;
                ap_d    = ap_i;
            end else if (row_open && ((sel_i && (cmd_i == CMD_PRE)) || (cmd_i == CMD_PALL))) begin
                state_d = BS_PRECH;
                cnt_d   = PRE_LAST;
            end else if (bursting && (cmd_i == CMD_BST)) begin
                state_d = BS_ACTIVE;
            end else if (bursting && is_col && !sel_i) begin
                if (ap_q) begin
                    state_d = BS_PRECH;
                    cnt_d   = PRE_LAST;
                end else begin
                    state_d = BS_ACTIVE;
                end
            end
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
            ap_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ap_q    <= ap_d;
        end
    end

    // R5
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_IDLE) |=> (state_q inside {BS_IDLE, BS_ACTIVE}));

    // R7
    prech_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_PRECH) |=> (state_q inside {BS_PRECH, BS_IDLE}));

    // R7
    prech_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == BS_PRECH) && ($past(state_q) != BS_PRECH))
        |-> ($past(state_q) inside {BS_ACTIVE, BS_READ, BS_WRITE}));

    // R8
    burst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == BS_READ) || (state_q == BS_WRITE)) |=> (state_q != BS_IDLE));
endmodule

// File: rtl/sdram_cmd_monitor.sv
// Module: sdram_cmd_monitor
// Passive monitor of a multi-bank SDRAM command bus. It decodes each cycle,
// tracks every bank and flags commands illegal in the current state. Assumes
// the pins are sampled on the rising clock edge and gaps are checked elsewhere.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 11,
    parameter int BURST_LEN = 4,
    parameter int PRE_CLKS  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke_i,
    input  logic                   cs_n_i,
    input  logic                   ras_n_i,
    input  logic                   cas_n_i,
    input  logic                   we_n_i,
    input  logic [1:0]             ba_i,
    input  logic [ADDR_W-1:0]      addr_i,
    output logic [3:0]             cmd_o,
    output logic [1:0]             cmd_bank_o,
    output logic [ADDR_W-1:0]      cmd_addr_o,
    output logic [3*NUM_BANKS-1:0] bank_state_o,
    output logic                   viol_o,
    output logic [2:0]             viol_code_o
);
    localparam int BA_W = $clog2(NUM_BANKS);

    cmd_e     cmd_d;
    logic     ap_d;
    bank_st_e st   [NUM_BANKS];
    rsn_e     rsn  [NUM_BANKS];
    rsn_e     rsn_c;
    logic     go, all_idle, any_burst, targeted;
    cmd_e     cmd_q;
    rsn_e     code_q;

    sdram_cmd_decode #(.ADDR_W(ADDR_W), .BA_W(2)) u_decode (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .ba_i    (ba_i),
        .addr_i  (addr_i),
        .cmd_o   (cmd_d),
        .ap_o    (ap_d)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_tracker #(.BURST_LEN(BURST_LEN), .PRE_CLKS(PRE_CLKS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd_d),
            .sel_i   (ba_i[BA_W-1:0] == BA_W'(b)),
            .ap_i    (ap_d),
            .go_i    (go),
            .state_o (st[b]),
            .rsn_o   (rsn[b])
        );
        assign bank_state_o[3*b +: 3] = st[b];
    end

    // Array-wide conditions used by refresh, mode set and burst stop.
    always_comb begin
        all_idle  = 1'b1;
        any_burst = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            all_idle  = all_idle && (st[i] == BS_IDLE);
            any_burst = any_burst || (st[i] == BS_READ) || (st[i] == BS_WRITE);
        end
    end

    assign targeted = cmd_d inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_ACT, CMD_PRE};

    // Pick the verdict: addressed bank for bank commands, array for the rest.
    always_comb begin
        rsn_c = RSN_NONE;
        if (targeted) begin
            rsn_c = rsn[ba_i[BA_W-1:0]];
        end else begin
            case (cmd_d)
                CMD_BST:          if (!any_burst) rsn_c = RSN_NO_BURST;
                CMD_REF, CMD_MRS: if (!all_idle)  rsn_c = RSN_NOT_IDLE;
                CMD_MRS_BAD:      rsn_c = RSN_BAD_MRS;
                default:          ;
            endcase
        end
    end

    assign go = (rsn_c == RSN_NONE);

    // Register the decoded command and the violation report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_DESL;
            cmd_bank_o <= '0;
            cmd_addr_o <= '0;
            viol_o     <= 1'b0;
            code_q     <= RSN_NONE;
        end else begin
            cmd_q      <= cmd_d;
            cmd_bank_o <= ba_i;
            cmd_addr_o <= addr_i;
            viol_o     <= !go;
            code_q     <= rsn_c;
        end
    end

    assign cmd_o       = cmd_q;
    assign viol_code_o = code_q;

    // R2
    desl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_DESL) |-> !viol_o);

    // R11
    ref_all_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o inside {CMD_REF, CMD_MRS}) && !viol_o) |-> all_idle);
endmodule

// File: tb/test_sdram_cmd_monitor.sv
// Directed bench: one task per scenario, each checking its own results.
module test_sdram_cmd_monitor;
    localparam int AW = 11;
    localparam logic [AW-1:0] A10 = 11'h400;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]    ba = '0;
    logic [AW-1:0] addr = '0;
    logic [3:0]    cmd;
    logic [1:0]    cmd_bank;
    logic [AW-1:0] cmd_addr;
    logic [11:0]   bstate;
    logic          viol;
    logic [2:0]    vcode;
    int            n_chk = 0;
    int            n_fail = 0;

    always #2 clk = ~clk;

    sdram_cmd_monitor #(.NUM_BANKS(4), .ADDR_W(AW), .BURST_LEN(2), .PRE_CLKS(3)) i_sdram_cmd_monitor (
        .clk (clk), .rst_n (rst_n), .cke_i (cke), .cs_n_i (cs_n), .ras_n_i (ras_n),
        .cas_n_i (cas_n), .we_n_i (we_n), .ba_i (ba), .addr_i (addr),
        .cmd_o (cmd), .cmd_bank_o (cmd_bank), .cmd_addr_o (cmd_addr),
        .bank_state_o (bstate), .viol_o (viol), .viol_code_o (vcode)
    );

    function automatic int st(input int b);
        return int'(bstate[3*b +: 3]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one command at the falling edge, sample just after the rising edge.
    task automatic send(input logic r, input logic c, input logic w,
                        input logic [1:0] b, input logic [AW-1:0] a);
        @(negedge clk);
        cs_n = 1'b0; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
        @(posedge clk);
        #1;
        cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = '0; addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic c_act(input logic [1:0] b);           send(0, 1, 1, b, 11'h023); endtask
    task automatic c_rd(input logic [1:0] b, input logic ap); send(1, 0, 1, b, ap ? A10 : '0); endtask
    task automatic c_wr(input logic [1:0] b, input logic ap); send(1, 0, 0, b, ap ? A10 : '0); endtask
    task automatic c_pre(input logic [1:0] b);           send(0, 1, 0, b, '0); endtask

    task automatic t_reset;
        chk("R1 bank states", int'(bstate), 0);
        chk("R1 cmd", int'(cmd), 0);
        chk("R1 viol", int'(viol), 0);
    endtask

    task automatic t_decode;
        send(1, 1, 1, 2'd0, '0);
        chk("R2 nop code", int'(cmd), 1);
        @(negedge clk);
        cs_n = 1'b1; ras_n = 1'b0; cas_n = 1'b1; we_n = 1'b1;
        @(posedge clk); #1;
        chk("R2 cs high is deselect", int'(cmd), 0);
        chk("R2 cs high bank0 unchanged", st(0), 0);
        cke = 1'b0;
        c_act(2'd0);
        cke = 1'b1;
        chk("R2 cke low is deselect", int'(cmd), 0);
        chk("R2 cke low no viol", int'(viol), 0);
        chk("R2 cke low bank0 unchanged", st(0), 0);
    endtask

    task automatic t_activate;
        c_act(2'd2);
        chk("R2 act code", int'(cmd), 7);
        chk("R4 bank2 open", st(2), 2);
        chk("R4 bank1 untouched", st(1), 0);
        chk("R4 cmd bank", int'(cmd_bank), 2);
        c_act(2'd2);
        chk("R5 act on open viol", int'(viol), 1);
        chk("R5 act on open reason", int'(vcode), 3);
        chk("R12 bank2 still open", st(2), 2);
        c_rd(2'd1, 1'b0);
        chk("R6 read idle reason", int'(vcode), 2);
        chk("R12 bank1 still idle", st(1), 0);
    endtask

    task automatic t_burst;
        c_rd(2'd2, 1'b0);
        chk("R2 read code", int'(cmd), 3);
        chk("R8 bank2 reading", st(2), 3);
        idle(1);
        chk("R8 still reading", st(2), 3);
        idle(1);
        chk("R8 back to open", st(2), 2);
        c_wr(2'd2, 1'b1);
        chk("R3 write ap code", int'(cmd), 6);
        chk("R8 bank2 writing", st(2), 4);
        idle(2);
        chk("R8 auto precharge", st(2), 1);
        idle(2);
        chk("R8 still precharging", st(2), 1);
        idle(1);
        chk("R8 idle after auto precharge", st(2), 0);
    endtask

    task automatic t_precharge;
        c_pre(2'd0);
        chk("R7 pre on idle no viol", int'(viol), 0);
        chk("R7 pre on idle no change", st(0), 0);
        c_act(2'd0);
        c_pre(2'd0);
        chk("R2 pre code", int'(cmd), 8);
        chk("R7 precharging", st(0), 1);
        c_rd(2'd0, 1'b0);
        chk("R6 read precharging reason", int'(vcode), 1);
        c_act(2'd0);
        chk("R6 act precharging reason", int'(vcode), 1);
        chk("R12 timer runs", st(0), 1);
        idle(1);
        chk("R7 idle after interval", st(0), 0);
        chk("R12 pulse one cycle", int'(viol), 0);
        c_act(2'd0);
        c_pre(2'd0);
        c_pre(2'd0);
        chk("R7 repeat pre no viol", int'(viol), 0);
        idle(1);
        chk("R7 repeat pre no restart", st(0), 1);
        idle(1);
        chk("R7 repeat pre idle on time", st(0), 0);
    endtask

    task automatic t_pall;
        c_act(2'd0);
        c_act(2'd1);
        c_rd(2'd1, 1'b0);
        send(0, 1, 0, 2'd3, A10);
        chk("R3 pall code", int'(cmd), 9);
        chk("R13 pall no viol", int'(viol), 0);
        chk("R13 bank0 precharging", st(0), 1);
        chk("R13 bank1 precharging", st(1), 1);
        chk("R13 bank3 idle kept", st(3), 0);
        idle(3);
        chk("R13 all idle later", int'(bstate), 0);
    endtask

    task automatic t_interrupt;
        c_act(2'd0);
        c_act(2'd3);
        c_rd(2'd0, 1'b1);
        c_wr(2'd3, 1'b0);
        chk("R9 bank3 writing", st(3), 4);
        chk("R9 ap burst cut to precharge", st(0), 1);
        c_rd(2'd3, 1'b0);
        chk("R9 write to read restart", st(3), 3);
        idle(2);
        chk("R9 restarted burst ends", st(3), 2);
        chk("R9 bank0 idle", st(0), 0);
        c_act(2'd1);
        c_rd(2'd1, 1'b0);
        c_wr(2'd3, 1'b0);
        chk("R9 plain burst cut to open", st(1), 2);
        idle(2);
    endtask

    task automatic t_bst;
        send(1, 1, 0, 2'd0, '0);
        chk("R10 bst no burst reason", int'(vcode), 4);
        c_rd(2'd3, 1'b0);
        send(1, 1, 0, 2'd0, '0);
        chk("R2 bst code", int'(cmd), 2);
        chk("R10 bst legal", int'(viol), 0);
        chk("R10 bst ends burst", st(3), 2);
    endtask

    task automatic t_ref_mrs;
        send(0, 0, 1, 2'd0, '0);
        chk("R11 ref with open rows", int'(vcode), 5);
        send(0, 1, 0, 2'd0, A10);
        idle(3);
        chk("R11 all idle before ref", int'(bstate), 0);
        send(0, 0, 1, 2'd0, '0);
        chk("R2 ref code", int'(cmd), 10);
        chk("R11 ref legal", int'(viol), 0);
        send(0, 0, 0, 2'd0, 11'h032);
        chk("R11 mrs code", int'(cmd), 11);
        chk("R11 mrs legal", int'(viol), 0);
        chk("R2 cmd addr", int'(cmd_addr), 32'h032);
        send(0, 0, 0, 2'd0, A10);
        chk("R3 malformed mrs code", int'(cmd), 12);
        chk("R3 malformed mrs reason", int'(vcode), 6);
        send(0, 0, 0, 2'd1, '0);
        chk("R3 mrs bank bits reason", int'(vcode), 6);
        c_act(2'd1);
        send(0, 0, 0, 2'd0, '0);
        chk("R11 mrs with open row", int'(vcode), 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        cs_n  = 1'b0;
        @(posedge clk); #1;
        t_decode;
        t_activate;
        t_burst;
        t_precharge;
        t_pall;
        t_interrupt;
        t_bst;
        t_ref_mrs;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule